// File: doc/BRIEF.md
# Quad DAC Command Interface

This block is the digital front end of a four-channel, 8-bit, double-buffered DAC. A host sends 12-bit command words over a three-wire serial link: a select line, a link clock and a data line. Each channel has two registers: a staging register, and a live register whose value drives the converter. The command word carries a 2-bit channel address, a 2-bit control code and an 8-bit data byte. It can stage a value, stage a value and make it live at once, broadcast a value to every channel, move every staged value to its live register, or do nothing. The same word format also selects the link clock edge on which the pass-through output changes.

A separate active-low apply input moves every staged value to its live register. The pass-through output repeats the bits that fall off the far end of the shift register, so several devices can share one select line in a chain. All logic runs on one system clock. The link clock, the select line, the data line and the apply input are oversampled and edge-detected. The serial link has no back-pressure: the host must pace the link clock slowly enough for the oversampling, and a command is never refused. The live values come out as four parallel 8-bit fields of one bus.

Top module: `qdac_cmd_if`

## Requirements
- R1: Bits are captured on rising link clock edges while `link_sel_n` is low and are taken MSB first in the order address[1:0], control[1:0], data[7:0]. The command executes when `link_sel_n` returns high. If fewer than 12 bits arrived, no command executes. If more than 12 arrived, the last 12 are used.
- R2: Control 01 writes the data byte to the staging register of the addressed channel (00 = field 0 ... 11 = field 3). `chan_q` is unchanged.
- R3: Control 11 writes the data byte to both the staging and the live register of the addressed channel.
- R4: Control 00 with address bit 0 = 0 writes the data byte to the staging and live registers of all four channels. Address bit 1 has no effect.
- R5: Control 00 with address bit 0 = 1 changes no register, staging or live.
- R6: Control 10 with address bit 1 = 0 copies every staging register into its live register. Address bit 0 and the data byte have no effect.
- R7: Control 10 with address 11 selects pass-through on the rising link clock edge. Control 10 with address 10 selects the falling edge. Both also copy every staging register to its live register. The rising edge is selected after reset.
- R8: While `apply_n` is low, every live register is loaded from its staging register on each system clock.
- R9: If a command executes in the same cycle that `apply_n` is seen low, the live registers take the staging values as they stand after the command.
- R10: `link_thru` presents the bit shifted out of the 12-bit shift register, updated on the selected link clock edge. In rising mode, the bit shifted out on rise j shows after that rise. In falling mode, after fall j it shows the bit that will leave on rise j+1. Bits sent 12 positions earlier therefore reappear.
- R11: Reset clears all staging and live registers to 0x00 and drives `link_thru` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| link_sel_n | input | 1 | Active-low frame select |
| link_clk | input | 1 | Serial link clock |
| link_data | input | 1 | Serial data into the shift register |
| apply_n | input | 1 | Active-low copy of all staging values to live |
| link_thru | output | 1 | Serial pass-through for chaining |
| chan_q | output | 32 | Live values; channel n in bits [8n+7:8n] |

## Verification
Two things can land in the same system cycle: a command executing at the end of a frame and the apply input being low. The bench provokes this by pulsing `apply_n` low for one system clock on the same clock edge at which `link_sel_n` returns high. Both inputs pass through identical synchronizers, so the two events meet in one cycle. The result counts as correct only if the written channel's live value equals the byte just staged by that command, not the older staged value.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int CTL_W   = 2;
  localparam int FRAME_W = ADDR_W + CTL_W + DATA_W;

  typedef enum logic [CTL_W-1:0] {
    CTL_SPECIAL = 2'b00,
    CTL_STAGE   = 2'b01,
    CTL_XFER    = 2'b10,
    CTL_BOTH    = 2'b11
  } ctl_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    ctl_e              ctl;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;
  logic [WIDTH-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      pipe <= {pipe[STAGES-2:0], pin};
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise[b] =  level[b] & ~prev[b];
    assign fall[b] = ~level[b] &  prev[b];
  end
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int FRAME = 12,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shift,
  input  logic             fall_tick,
  input  logic             bit_in,
  input  logic             mode_rise,
  output logic [FRAME-1:0] word,
  output logic             full,
  output logic             thru
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
      thru <= 1'b0;
    end else begin
      if (shift) word <= {word[FRAME-2:0], bit_in};
      if (start)
        cnt <= shift ? CNT_W'(1) : '0;
      else if (shift && cnt != CNT_W'(FRAME))
        cnt <= cnt + CNT_W'(1);
      if ((mode_rise && shift) || (!mode_rise && fall_tick))
        thru <= word[FRAME-1];
    end
  end

  assign full = (cnt == CNT_W'(FRAME));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  localparam int FLAT_W = NCH * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  cmd_t              cmd,
  input  logic              load_act,
  output logic [FLAT_W-1:0] in_flat,
  output logic [FLAT_W-1:0] out_flat,
  output logic              mode_rise
);
  logic [NCH-1:0][DATA_W-1:0] in_q, in_nxt, out_q, out_nxt;
  logic mode_nxt;

  always_comb begin
    in_nxt   = in_q;
    out_nxt  = out_q;
    mode_nxt = mode_rise;
    if (exec) begin
      unique case (cmd.ctl)
        CTL_STAGE: in_nxt[cmd.addr] = cmd.data;
        CTL_BOTH: begin
          in_nxt[cmd.addr]  = cmd.data;
          out_nxt[cmd.addr] = cmd.data;
        end
        CTL_SPECIAL: begin
          if (!cmd.addr[0]) begin
            for (int c = 0; c < NCH; c++) begin
              in_nxt[c]  = cmd.data;
              out_nxt[c] = cmd.data;
            end
          end
        end
        CTL_XFER: begin
          if (cmd.addr[1]) mode_nxt = cmd.addr[0];
          out_nxt = in_q;
        end
        default: ;
      endcase
    end
    if (load_act) out_nxt = in_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q      <= '0;
      out_q     <= '0;
      mode_rise <= 1'b1;
    end else begin
      in_q      <= in_nxt;
      out_q     <= out_nxt;
      mode_rise <= mode_nxt;
    end
  end

  assign in_flat  = in_q;
  assign out_flat = out_q;
endmodule

// File: rtl/qdac_cmd_if.sv
module qdac_cmd_if
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_sel_n,
  input  logic        link_clk,
  input  logic        link_data,
  input  logic        apply_n,
  output logic        link_thru,
  output logic [31:0] chan_q
);
  localparam int NCH = 4;
  localparam int PIN_N = 4;
  localparam int P_CLK = 0, P_SEL = 1, P_DAT = 2, P_APL = 3;

  logic [PIN_N-1:0] pins, lvl, rise, fall;
  logic [FRAME_W-1:0] cmd_word;
  logic [NCH*DATA_W-1:0] in_flat;
  logic sel_act, shift, fall_tick, full, exec_stb, load_act, mode_rise;

  assign pins = {apply_n, link_data, link_sel_n, link_clk};

  qdac_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .IDLE(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pins),
    .level(lvl), .rise(rise), .fall(fall)
  );

  assign sel_act   = ~lvl[P_SEL];
  assign shift     = rise[P_CLK] & sel_act;
  assign fall_tick = fall[P_CLK] & sel_act;
  assign load_act  = ~lvl[P_APL];

  qdac_shift #(.FRAME(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(fall[P_SEL]), .shift(shift),
    .fall_tick(fall_tick), .bit_in(lvl[P_DAT]), .mode_rise(mode_rise),
    .word(cmd_word), .full(full), .thru(link_thru)
  );

  assign exec_stb = rise[P_SEL] & full;

  qdac_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .exec(exec_stb), .cmd(cmd_t'(cmd_word)),
    .load_act(load_act), .in_flat(in_flat), .out_flat(chan_q),
    .mode_rise(mode_rise)
  );

  logic unused_edges;
  assign unused_edges = ^{rise[P_DAT], fall[P_DAT], rise[P_APL], fall[P_APL]};
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_stb,
  input logic        load_act,
  input logic        mode_rise,
  input logic [11:0] cmd_word,
  input logic [31:0] in_flat,
  input logic [31:0] chan_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> chan_q == 32'h0); // R11

  AST_STAGE_HOLDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd_word[9:8] == 2'b01 && !load_act |=> $stable(chan_q)); // R2

  AST_BOTH_WRITES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd_word[9:8] == 2'b11 |=>
      chan_q[{$past(cmd_word[11:10]), 3'b000} +: 8] == $past(cmd_word[7:0])); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb && !load_act |=> $stable(chan_q) && $stable(mode_rise)); // R5

  AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_rise) |-> $past(exec_stb && cmd_word[9:8] == 2'b10 && cmd_word[11])); // R7

  AST_APPLY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_act && !exec_stb |=> chan_q == $past(in_flat)); // R8

  AST_COINCIDE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && load_act |=> chan_q == in_flat); // R9
endmodule

bind qdac_cmd_if qdac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .load_act(load_act),
  .mode_rise(mode_rise), .cmd_word(cmd_word), .in_flat(in_flat), .chan_q(chan_q)
);

// File: tb/test_qdac_cmd_if.sv
module test_qdac_cmd_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_sel_n = 1'b1, link_clk = 1'b0, link_data = 1'b0, apply_n = 1'b1;
  logic link_thru;
  logic [31:0] chan_q;

  int checks = 0, fails = 0;
  logic [3:0][7:0] m_in, m_out;
  logic m_mode;
  logic [31:0] cap;

  always #4 clk = ~clk;

  qdac_cmd_if i_qdac_cmd_if (
    .clk(clk), .rst_n(rst_n), .link_sel_n(link_sel_n), .link_clk(link_clk),
    .link_data(link_data), .apply_n(apply_n), .link_thru(link_thru), .chan_q(chan_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(chan_q === m_out, req, chan_q, m_out);
  endtask

  function automatic logic [11:0] mk(input logic [1:0] a, input logic [1:0] c, input logic [7:0] d);
    return {a, c, d};
  endfunction

  task automatic m_exec(input logic [11:0] w);
    logic [1:0] a = w[11:10];
    logic [1:0] c = w[9:8];
    logic [7:0] d = w[7:0];
    case (c)
      2'b01: m_in[a] = d;
      2'b11: begin m_in[a] = d; m_out[a] = d; end
      2'b00: if (!a[0]) for (int i = 0; i < 4; i++) begin m_in[i] = d; m_out[i] = d; end
      default: begin
        if (a[1]) m_mode = a[0];
        m_out = m_in;
      end
    endcase
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, input bit ld_pulse);
    @(negedge clk); link_sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      link_data = bits[n-1-i];
      repeat (8) @(negedge clk); link_clk = 1'b1;
      repeat (8) @(negedge clk); link_clk = 1'b0;
      repeat (6) @(negedge clk); cap[i] = link_thru;
      repeat (2) @(negedge clk);
    end
    link_sel_n = 1'b1;
    if (ld_pulse) apply_n = 1'b0;
    @(negedge clk); apply_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input logic [11:0] w, input string req);
    xfer({20'h0, w}, 12, 1'b0);
    m_exec(w);
    chk_out(req);
  endtask

  task automatic chain(input logic [11:0] f, input logic [11:0] g, input bit rise_mode);
    logic [23:0] s = {f, g};
    xfer({8'h0, s}, 24, 1'b0);
    m_exec(g);
    chk_out("R1 long frame executes last 12");
    for (int j = 13; j <= 24; j++) begin
      logic e = rise_mode ? s[23-(j-13)] : s[23-(j-12)];
      chk(cap[j-1] === e, rise_mode ? "R10 rising pass-through" : "R10 falling pass-through", cap[j-1], e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_in = '0; m_out = '0; m_mode = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(chan_q === 32'h0, "R11 reset clears live values", chan_q, 0);
    chk(link_thru === 1'b0, "R11 reset pass-through low", link_thru, 0);

    send(mk(2'b01, 2'b01, 8'h5A), "R2 stage only keeps live");
    send(mk(2'b01, 2'b10, 8'hFF), "R6 transfer ignores addr bit 0 and data");
    send(mk(2'b11, 2'b11, 8'hC3), "R3 stage and live");
    send(mk(2'b10, 2'b00, 8'h77), "R4 broadcast ignores addr bit 1");
    send(mk(2'b01, 2'b00, 8'h12), "R5 nop keeps live");
    send(mk(2'b00, 2'b10, 8'h00), "R5 nop kept staging values");

    xfer({21'h0, 11'h3F5}, 11, 1'b0);
    chk_out("R1 short frame ignored");
    send(mk(2'b00, 2'b10, 8'h00), "R1 short frame left staging");
    xfer({16'h0, 4'hF, mk(2'b11, 2'b11, 8'hAB)}, 16, 1'b0);
    m_exec(mk(2'b11, 2'b11, 8'hAB));
    chk_out("R1 overlong frame uses last 12");

    send(mk(2'b00, 2'b01, 8'h11), "R2 stage channel 0");
    @(negedge clk); apply_n = 1'b0;
    repeat (4) @(negedge clk); apply_n = 1'b1;
    repeat (6) @(negedge clk);
    m_out = m_in;
    chk_out("R8 apply pin copies staging");

    xfer({20'h0, mk(2'b10, 2'b01, 8'h99)}, 12, 1'b1);
    m_exec(mk(2'b10, 2'b01, 8'h99));
    m_out = m_in;
    chk_out("R9 coincident apply takes new staging");

    send(mk(2'b01, 2'b01, 8'h3C), "R2 stage before mode change");
    chain(12'hB6D, mk(2'b00, 2'b01, 8'h4E), 1'b1);
    send(mk(2'b10, 2'b10, 8'h55), "R7 falling mode command transfers");
    chain(12'h9A5, mk(2'b11, 2'b01, 8'hE1), 1'b0);
    send(mk(2'b11, 2'b10, 8'h00), "R7 rising mode command transfers");
    chain(12'h5C3, mk(2'b00, 2'b00, 8'h66), 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom_range(0, 255));
      int t = $urandom_range(0, 4);
      logic [1:0] c = (t == 0) ? 2'b01 : (t == 1) ? 2'b11 : (t == 2) ? 2'b00 : 2'b10;
      if (c == 2'b10) a[1] = 1'b0;
      send(mk(a, c, d), "R2 R3 R4 R5 R6 random command");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule